// File: doc/BRIEF.md
# Four-State Snooping Cache Coherence Controller

This block is the coherence controller of one private cache on a shared snooping bus. The cache is direct-mapped, and each line holds one data word. Every line is in one of four states: invalid, clean-sharable, clean-exclusive or dirty-exclusive. The controller handles CPU reads and writes. It issues bus reads, read-for-ownership requests, invalidations and write-backs through a request/acknowledge master port. It also watches the transactions that other caches put on the bus and answers them on a snoop port.

On a read fill, a wired-OR shared line tells the controller whether another cache already holds the line. It samples that line together with the fill acknowledge. If no other cache responds, the line is filled as clean-exclusive, and a later CPU write upgrades it to dirty silently. A write to a clean-sharable line costs one address-only invalidation on the bus. When a snooped read or read-for-ownership hits a dirty line, the controller puts the line's data on the snoop data path so that memory and the requester can take it. Memory and bus arbitration are outside the block.

Top module: `coh_snoop_ctrl`

## Requirements
- R1: After reset every line is invalid, `mReq` and `cpuDone` are low, and no snoop gets a response.
- R2: A CPU read that hits returns the line's word on `cpuRdata` in the single-cycle `cpuDone` pulse. It makes no bus request and leaves the line state unchanged.
- R3: A CPU read miss issues a bus read (`mCmd`=0) for the request address. The returned word is stored and returned. The line becomes clean-sharable if `mShared` is high in the acknowledge cycle, and clean-exclusive otherwise.
- R4: A CPU write that hits a clean-exclusive or dirty-exclusive line stores the word and leaves the line dirty-exclusive, with no bus request.
- R5: A CPU write that hits a clean-sharable line issues an invalidate (`mCmd`=2) for the request address. It waits for `mAck`, then stores the word and leaves the line dirty-exclusive.
- R6: A CPU write miss issues a read-for-ownership (`mCmd`=1) for the request address. On `mAck` the line takes the CPU word and becomes dirty-exclusive.
- R7: A snooped read (`snCmd`=0) that hits a held line raises `snShared` in the same cycle. A clean-exclusive line becomes clean-sharable, and a clean-sharable line stays so.
- R8: A snooped read or read-for-ownership that hits a dirty-exclusive line raises `snSupply` in the same cycle with the line's word on `snData`. After a read the line is clean-sharable.
- R9: A snooped read-for-ownership (`snCmd`=1) or invalidate (`snCmd`=2) that hits a held line leaves it invalid.
- R10: A snoop whose tag does not match, or whose line is invalid, raises neither `snShared` nor `snSupply` and changes no line.
- R11: A miss whose victim line is dirty-exclusive first issues a write-back (`mCmd`=3) carrying the victim's address and word, and only then issues the fill request.
- R12: `mReq` stays high until `mAck`, with command and address held steady. `cpuDone` is a one-cycle pulse. The index is the low log2(LINES) address bits, and the tag is the rest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | CPU request, held until `cpuDone` |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | CPU word address |
| cpuWdata | input | DATA_W | CPU write word |
| cpuRdata | output | DATA_W | Read result, valid with `cpuDone` |
| cpuDone | output | 1 | One-cycle completion pulse |
| mReq | output | 1 | Bus master request |
| mCmd | output | 2 | 0 read, 1 read-for-ownership, 2 invalidate, 3 write-back |
| mAddr | output | ADDR_W | Bus request address |
| mWdata | output | DATA_W | Write-back word |
| mAck | input | 1 | Bus transaction complete |
| mRdata | input | DATA_W | Fill word, valid with `mAck` |
| mShared | input | 1 | Wired-OR shared line, sampled with `mAck` |
| snValid | input | 1 | Snooped transaction valid |
| snCmd | input | 2 | Snooped command, same encoding as `mCmd` |
| snAddr | input | ADDR_W | Snooped address |
| snShared | output | 1 | This cache holds the snooped read line |
| snSupply | output | 1 | This cache supplies dirty data |
| snData | output | DATA_W | Supplied word, zero when not supplying |

## Verification
A single line is walked through every state pair, and its state is inferred from whether the next CPU write is silent or issues an invalidate. A design that filled exclusively despite `mShared` would let a write to shared data skip the invalidate. A design that ignored the shared line the other way would spend bus cycles on private writes. Snoops are aimed at dirty, exclusive, shared and stale-tag lines. A controller that forgot to supply dirty data would lose the newest word, and one that matched only on index would answer for a line it no longer holds. A conflict miss on a dirty victim checks that the write-back comes before the fill with the old address and word; getting the order wrong would overwrite memory with stale data or drop the dirty word.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_CS  = 2'd1,
    LN_CE  = 2'd2,
    LN_DE  = 2'd3
  } lineState_e;

  typedef enum logic [1:0] {
    BUS_RD  = 2'd0,
    BUS_RFO = 2'd1,
    BUS_INV = 2'd2,
    BUS_WB  = 2'd3
  } busCmd_e;

  typedef enum logic [1:0] {
    C_IDLE = 2'd0,
    C_WB   = 2'd1,
    C_FILL = 2'd2,
    C_UPG  = 2'd3
  } ctlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       capture;     // latch the CPU request
    logic       selLive;     // look up the live CPU address
    logic       wrLine;      // write state and tag of the active line
    lineState_e newState;
    logic       wrData;      // write the active line's word
    logic       dataFromBus; // word source: bus fill instead of CPU
    logic       loadRdata;   // update cpuRdata
    logic       victimAddr;  // bus address is the resident line's
  } strobe_t;

endpackage

// File: rtl/coh_datapath.sv
module coh_datapath
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] mRdata,
  input  logic              snValid,
  input  logic [1:0]        snCmd,
  input  logic [ADDR_W-1:0] snAddr,
  output lineState_e        hitState,
  output logic              victimDirty,
  output logic [DATA_W-1:0] cpuRdata,
  output logic [ADDR_W-1:0] mAddr,
  output logic [DATA_W-1:0] mWdata,
  output logic              snShared,
  output logic              snSupply,
  output logic [DATA_W-1:0] snData
);

  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  lineState_e        stArr   [LINES];
  logic [TAG_W-1:0]  tagArr  [LINES];
  logic [DATA_W-1:0] dataArr [LINES];

  logic [ADDR_W-1:0] reqAddr;
  logic [DATA_W-1:0] reqWdata;

  // CPU-side lookup
  logic [ADDR_W-1:0] actAddr;
  logic [DATA_W-1:0] actWdata;
  logic [IDX_W-1:0]  actIdx;
  logic [TAG_W-1:0]  actTag;

  assign actAddr  = strb.selLive ? cpuAddr : reqAddr;
  assign actWdata = strb.selLive ? cpuWdata : reqWdata;
  assign actIdx   = actAddr[IDX_W-1:0];
  assign actTag   = actAddr[ADDR_W-1:IDX_W];

  always_comb begin
    hitState    = LN_INV;
    if (stArr[actIdx] != LN_INV && tagArr[actIdx] == actTag)
      hitState = stArr[actIdx];
    victimDirty = (stArr[actIdx] == LN_DE) && (tagArr[actIdx] != actTag);
  end

  assign mAddr  = strb.victimAddr ? {tagArr[actIdx], actIdx} : actAddr;
  assign mWdata = dataArr[actIdx];

  // snoop-side lookup, a second read port on the directory
  logic [IDX_W-1:0] snIdx;
  logic [TAG_W-1:0] snTag;
  logic             snHit;
  logic             snIsRd;
  logic             snIsKill;
  logic             snChange;
  lineState_e       snNext;
  logic             ctlSame;

  assign snIdx    = snAddr[IDX_W-1:0];
  assign snTag    = snAddr[ADDR_W-1:IDX_W];
  assign snHit    = snValid && stArr[snIdx] != LN_INV && tagArr[snIdx] == snTag;
  assign snIsRd   = (snCmd == BUS_RD);
  assign snIsKill = (snCmd == BUS_RFO) || (snCmd == BUS_INV);
  assign snChange = snHit && (snIsRd || snIsKill);
  assign ctlSame  = strb.wrLine && (actIdx == snIdx);

  always_comb begin
    snNext = stArr[snIdx];
    if (snIsKill)
      snNext = LN_INV;
    else if (snIsRd && (stArr[snIdx] == LN_CE || stArr[snIdx] == LN_DE))
      snNext = LN_CS;
  end

  assign snShared = snHit && snIsRd;
  assign snSupply = snHit && (stArr[snIdx] == LN_DE) && (snIsRd || snCmd == BUS_RFO);
  assign snData   = snSupply ? dataArr[snIdx] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) begin
        stArr[i]   <= LN_INV;
        tagArr[i]  <= '0;
        dataArr[i] <= '0;
      end
      reqAddr  <= '0;
      reqWdata <= '0;
      cpuRdata <= '0;
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (strb.wrLine && actIdx == IDX_W'(i))
          stArr[i] <= strb.newState;
        else if (snChange && snIdx == IDX_W'(i))
          stArr[i] <= snNext;
      end
      if (strb.wrLine)
        tagArr[actIdx] <= actTag;
      if (strb.wrData)
        dataArr[actIdx] <= strb.dataFromBus ? mRdata : actWdata;
      if (strb.loadRdata)
        cpuRdata <= strb.dataFromBus ? mRdata : dataArr[actIdx];
      if (strb.capture) begin
        reqAddr  <= cpuAddr;
        reqWdata <= cpuWdata;
      end
    end
  end

  // checker state: what the snoop seen last cycle should have done
  logic             snRdHitQ;
  logic             snKillQ;
  logic [IDX_W-1:0] snIdxQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      snRdHitQ <= 1'b0;
      snKillQ  <= 1'b0;
      snIdxQ   <= '0;
    end else begin
      snRdHitQ <= snHit && snIsRd && !ctlSame;
      snKillQ  <= snHit && snIsKill && !ctlSame;
      snIdxQ   <= snIdx;
    end
  end

  assert_snoop_read_share_R7: assert property (@(posedge clk) disable iff (!rstN)
    snRdHitQ |-> stArr[snIdxQ] == LN_CS);

  assert_snoop_kill_R9: assert property (@(posedge clk) disable iff (!rstN)
    snKillQ |-> stArr[snIdxQ] == LN_INV);

  assert_supply_data_R8: assert property (@(posedge clk) disable iff (!rstN)
    !snSupply |-> snData == '0);

endmodule

// File: rtl/coh_control.sv
module coh_control
  import coh_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuReq,
  input  logic       cpuWrite,
  input  lineState_e hitState,
  input  logic       victimDirty,
  input  logic       mAck,
  input  logic       mShared,
  output strobe_t    strb,
  output logic       mReq,
  output logic [1:0] mCmd,
  output logic       cpuDone
);

  ctlState_e state, stateNext;
  logic      reqWrite;
  logic      doneNext;

  always_comb begin
    strb      = '0;
    stateNext = state;
    doneNext  = 1'b0;
    mReq      = 1'b0;
    mCmd      = BUS_RD;
    unique case (state)
      C_IDLE: begin
        if (cpuReq && !cpuDone) begin
          strb.selLive = 1'b1;
          strb.capture = 1'b1;
          if (hitState != LN_INV) begin
            if (!cpuWrite) begin
              strb.loadRdata = 1'b1;
              doneNext       = 1'b1;
            end else if (hitState == LN_CS) begin
              stateNext = C_UPG;
            end else begin
              strb.wrLine   = 1'b1;
              strb.newState = LN_DE;
              strb.wrData   = 1'b1;
              doneNext      = 1'b1;
            end
          end else if (victimDirty) begin
            stateNext = C_WB;
          end else begin
            stateNext = C_FILL;
          end
        end
      end
      C_WB: begin
        mReq            = 1'b1;
        mCmd            = BUS_WB;
        strb.victimAddr = 1'b1;
        if (mAck)
          stateNext = C_FILL;
      end
      C_FILL: begin
        mReq = 1'b1;
        mCmd = reqWrite ? BUS_RFO : BUS_RD;
        if (mAck) begin
          strb.wrLine      = 1'b1;
          strb.wrData      = 1'b1;
          strb.dataFromBus = !reqWrite;
          strb.loadRdata   = !reqWrite;
          strb.newState    = reqWrite ? LN_DE : (mShared ? LN_CS : LN_CE);
          doneNext         = 1'b1;
          stateNext        = C_IDLE;
        end
      end
      C_UPG: begin
        mReq = 1'b1;
        mCmd = BUS_INV;
        if (mAck) begin
          strb.wrLine   = 1'b1;
          strb.newState = LN_DE;
          strb.wrData   = 1'b1;
          doneNext      = 1'b1;
          stateNext     = C_IDLE;
        end
      end
      default: stateNext = C_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= C_IDLE;
      reqWrite <= 1'b0;
      cpuDone  <= 1'b0;
    end else begin
      state   <= stateNext;
      cpuDone <= doneNext;
      if (strb.capture)
        reqWrite <= cpuWrite;
    end
  end

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    mReq && !mAck |=> mReq && $stable(mCmd));

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |=> !cpuDone);

  assert_silent_upgrade_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == C_IDLE && cpuReq && !cpuDone && cpuWrite && hitState == LN_CE)
      |=> cpuDone && !mReq);

  assert_wb_then_fill_R11: assert property (@(posedge clk) disable iff (!rstN)
    mReq && mAck && mCmd == BUS_WB |=> mReq && mCmd != BUS_WB);

endmodule

// File: rtl/coh_snoop_ctrl.sv
module coh_snoop_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuDone,
  output logic              mReq,
  output logic [1:0]        mCmd,
  output logic [ADDR_W-1:0] mAddr,
  output logic [DATA_W-1:0] mWdata,
  input  logic              mAck,
  input  logic [DATA_W-1:0] mRdata,
  input  logic              mShared,
  input  logic              snValid,
  input  logic [1:0]        snCmd,
  input  logic [ADDR_W-1:0] snAddr,
  output logic              snShared,
  output logic              snSupply,
  output logic [DATA_W-1:0] snData
);

  strobe_t    strb;
  lineState_e hitState;
  logic       victimDirty;

  coh_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .cpuReq     (cpuReq),
    .cpuWrite   (cpuWrite),
    .hitState   (hitState),
    .victimDirty(victimDirty),
    .mAck       (mAck),
    .mShared    (mShared),
    .strb       (strb),
    .mReq       (mReq),
    .mCmd       (mCmd),
    .cpuDone    (cpuDone)
  );

  coh_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LINES (LINES)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cpuAddr    (cpuAddr),
    .cpuWdata   (cpuWdata),
    .mRdata     (mRdata),
    .snValid    (snValid),
    .snCmd      (snCmd),
    .snAddr     (snAddr),
    .hitState   (hitState),
    .victimDirty(victimDirty),
    .cpuRdata   (cpuRdata),
    .mAddr      (mAddr),
    .mWdata     (mWdata),
    .snShared   (snShared),
    .snSupply   (snSupply),
    .snData     (snData)
  );

endmodule

// File: tb/coh_snoop_ctrl_bench.sv
module coh_snoop_ctrl_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuReq = 1'b0;
  logic        cpuWrite = 1'b0;
  logic [7:0]  cpuAddr = '0;
  logic [15:0] cpuWdata = '0;
  logic [15:0] cpuRdata;
  logic        cpuDone;
  logic        mReq;
  logic [1:0]  mCmd;
  logic [7:0]  mAddr;
  logic [15:0] mWdata;
  logic        mAck = 1'b0;
  logic [15:0] mRdata = '0;
  logic        mShared = 1'b0;
  logic        snValid = 1'b0;
  logic [1:0]  snCmd = '0;
  logic [7:0]  snAddr = '0;
  logic        snShared;
  logic        snSupply;
  logic [15:0] snData;

  always #2.5ns clk = ~clk;

  coh_snoop_ctrl u_coh_snoop_ctrl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWrite(cpuWrite),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .cpuDone(cpuDone),
    .mReq(mReq), .mCmd(mCmd), .mAddr(mAddr), .mWdata(mWdata), .mAck(mAck),
    .mRdata(mRdata), .mShared(mShared), .snValid(snValid), .snCmd(snCmd),
    .snAddr(snAddr), .snShared(snShared), .snSupply(snSupply), .snData(snData)
  );

  int checks = 0;
  int errors = 0;
  bit busy = 1'b0;
  bit finished = 1'b0;

  // behavioural model: 0 invalid, 1 clean-sharable, 2 clean-exclusive, 3 dirty
  int          mSt [8];
  logic [4:0]  mTg [8];
  logic [15:0] mDt [8];
  logic [15:0] mem [256];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // every clock while no CPU operation runs: the controller stays quiet
  always @(negedge clk) begin
    if (rstN && !busy && !finished) begin
      chk(!mReq && !cpuDone, "R12", "idle bus/done", {30'd0, mReq, cpuDone}, 32'd0);
    end
  end

  task automatic cpuOp(input bit wr, input logic [7:0] a, input logic [15:0] d,
                       input bit shr, input string req);
    int idx = int'(a[2:0]);
    logic [4:0]  tg = a[7:3];
    bit hit = (mSt[idx] != 0) && (mTg[idx] == tg);
    logic [1:0]  eCmd [3];
    logic [7:0]  eAd  [3];
    logic [15:0] eWd  [3];
    int nExp = 0;
    int nSeen = 0;
    int hold = 0;
    bit gotDone = 0;
    logic [15:0] eRd = mDt[idx];
    if (!hit) begin
      if (mSt[idx] == 3) begin
        eCmd[nExp] = 2'd3; eAd[nExp] = {mTg[idx], a[2:0]}; eWd[nExp] = mDt[idx]; nExp++;
      end
      eCmd[nExp] = wr ? 2'd1 : 2'd0; eAd[nExp] = a; eWd[nExp] = '0; nExp++;
      eRd = mem[a];
    end else if (wr && mSt[idx] == 1) begin
      eCmd[nExp] = 2'd2; eAd[nExp] = a; eWd[nExp] = '0; nExp++;
    end
    busy = 1'b1;
    @(negedge clk);
    cpuReq = 1'b1; cpuWrite = wr; cpuAddr = a; cpuWdata = d; mShared = shr;
    for (int cyc = 0; cyc < 60; cyc++) begin
      @(negedge clk);
      if (mAck) mAck = 1'b0;
      if (cpuDone) begin gotDone = 1; break; end
      if (mReq) begin
        if (hold == 0) begin
          chk(nSeen < nExp, req, "unexpected bus request", {30'd0, mCmd}, 32'd0);
          if (nSeen < nExp) begin
            chk(mCmd == eCmd[nSeen], req, "bus command", {30'd0, mCmd}, {30'd0, eCmd[nSeen]});
            chk(mAddr == eAd[nSeen], req, "bus address", {24'd0, mAddr}, {24'd0, eAd[nSeen]});
            if (eCmd[nSeen] == 2'd3)
              chk(mWdata == eWd[nSeen], "R11", "write-back word", {16'd0, mWdata}, {16'd0, eWd[nSeen]});
          end
        end else begin
          chk(mCmd == eCmd[nSeen] && mAddr == eAd[nSeen], "R12", "request held",
              {22'd0, mCmd, mAddr}, {22'd0, eCmd[nSeen], eAd[nSeen]});
        end
        hold++;
        if (hold == 2) begin
          mRdata = mem[mAddr];
          if (mCmd == 2'd3) mem[mAddr] = mWdata;
          mAck = 1'b1;
          nSeen++;
          hold = 0;
        end
      end
    end
    cpuReq = 1'b0;
    chk(gotDone, req, "completion", {31'd0, gotDone}, 32'd1);
    chk(nSeen == nExp, req, "bus transaction count", nSeen, nExp);
    if (!wr)
      chk(cpuRdata == eRd, req, "read word", {16'd0, cpuRdata}, {16'd0, eRd});
    // model update
    if (!hit) begin
      mTg[idx] = tg;
      if (wr) begin mSt[idx] = 3; mDt[idx] = d; end
      else begin mSt[idx] = shr ? 1 : 2; mDt[idx] = mem[a]; end
    end else if (wr) begin
      mSt[idx] = 3; mDt[idx] = d;
    end
    @(negedge clk);
    busy = 1'b0;
  endtask

  task automatic snoop(input logic [1:0] c, input logic [7:0] a, input string req);
    int idx = int'(a[2:0]);
    bit hit = (mSt[idx] != 0) && (mTg[idx] == a[7:3]);
    bit eSh = hit && (c == 2'd0);
    bit eSup = hit && (mSt[idx] == 3) && (c == 2'd0 || c == 2'd1);
    logic [15:0] eDat = eSup ? mDt[idx] : 16'd0;
    @(negedge clk);
    snValid = 1'b1; snCmd = c; snAddr = a;
    #1ns;
    chk(snShared == eSh, req, "snoop shared", {31'd0, snShared}, {31'd0, eSh});
    chk(snSupply == eSup, req, "snoop supply", {31'd0, snSupply}, {31'd0, eSup});
    chk(snData == eDat, req, "snoop data", {16'd0, snData}, {16'd0, eDat});
    if (eSup) mem[a] = mDt[idx];
    if (hit) begin
      if (c == 2'd0 && mSt[idx] >= 2) mSt[idx] = 1;
      else if (c == 2'd1 || c == 2'd2) mSt[idx] = 0;
    end
    @(negedge clk);
    snValid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 257) ^ 16'h5a00;
    for (int i = 0; i < 8; i++) begin mSt[i] = 0; mTg[i] = '0; mDt[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(!mReq && !cpuDone, "R1", "outputs after reset", {30'd0, mReq, cpuDone}, 32'd0);
    snoop(2'd0, 8'h00, "R1");
    snoop(2'd0, 8'h11, "R1");
    // R3 exclusive fill, R2 hit, R4 silent upgrade
    cpuOp(1'b0, 8'h11, 16'h0, 1'b0, "R3");
    cpuOp(1'b0, 8'h11, 16'h0, 1'b0, "R2");
    cpuOp(1'b1, 8'h11, 16'hbeef, 1'b0, "R4");
    cpuOp(1'b0, 8'h11, 16'h0, 1'b0, "R2");
    // R8 dirty supply on read, R5 upgrade from sharable
    snoop(2'd0, 8'h11, "R8");
    cpuOp(1'b1, 8'h11, 16'h1234, 1'b0, "R5");
    snoop(2'd1, 8'h11, "R8");
    // R3 sharable fill, R7 stays sharable, R9 invalidate
    cpuOp(1'b0, 8'h11, 16'h0, 1'b1, "R3");
    snoop(2'd0, 8'h11, "R7");
    snoop(2'd2, 8'h11, "R9");
    snoop(2'd0, 8'h11, "R10");
    cpuOp(1'b0, 8'h11, 16'h0, 1'b0, "R3");
    snoop(2'd0, 8'h11, "R7");
    cpuOp(1'b1, 8'h11, 16'h4321, 1'b0, "R5");
    // R11 dirty victim, R6 write miss, R10 stale tag
    cpuOp(1'b1, 8'h39, 16'h7777, 1'b0, "R6");
    snoop(2'd0, 8'h11, "R10");
    snoop(2'd1, 8'h11, "R10");
    cpuOp(1'b0, 8'h11, 16'h0, 1'b1, "R11");
    cpuOp(1'b0, 8'h39, 16'h0, 1'b0, "R11");
    // clean victim needs no write-back
    cpuOp(1'b0, 8'h22, 16'h0, 1'b0, "R3");
    cpuOp(1'b0, 8'h42, 16'h0, 1'b0, "R3");
    cpuOp(1'b1, 8'h07, 16'hcafe, 1'b1, "R6");
    cpuOp(1'b0, 8'h07, 16'h0, 1'b0, "R2");
    snoop(2'd2, 8'h05, "R10");
    snoop(2'd1, 8'h07, "R9");
    // sweep of every index with alternating sharing and writes
    for (int i = 0; i < 8; i++) begin
      cpuOp(1'b0, 8'(8'h80 + i), 16'h0, i[0], "R3");
      cpuOp(1'b1, 8'(8'h80 + i), 16'(16'h0a00 + i), 1'b0, i[0] ? "R5" : "R4");
      cpuOp(1'b1, 8'(8'hc8 + i), 16'(16'h0b00 + i), 1'b0, "R11");
      snoop(2'd0, 8'(8'hc8 + i), "R8");
      snoop(2'd2, 8'(8'hc8 + i), "R9");
    end
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule